// File: doc/BRIEF.md
# Multi-Channel Sample Output Port

This block gathers complex samples from up to six gain-control channels and sends them out over one 16-bit word bus. Every channel owns a one-sample holding slot. A separate shadow register carries the sample currently on the bus, so the holding slot is free again as soon as a transfer starts. Enabled channels with a waiting sample are served lowest index first. Each sample goes out as an I word followed by a Q word. When gain appending is on, a third word carries the channel's gain. Three side-band outputs travel with every word: the channel number, a flag that marks the Q word, and a flag that marks the gain word.

The port can run as a slave or as a master. As a slave it raises a request, and a word moves only in a cycle where the acknowledge input is high. As a master it ignores the acknowledge input and drives one word per cycle. A format input chooses between two modes. In interleaved mode every word needs its own grant. In paired mode one grant on the I word moves both I and Q, and Q appears in the following cycle. Channels with enable low are ignored completely. If a new sample reaches a channel whose slot still holds an unsent sample, the new sample replaces the old one and a sticky per-channel overflow flag is set.

Top module: `sample_out_port`

## Requirements
- R1: After reset, `port_req`, `port_iq` and `port_gain` are low and all `ovf_flag` bits are 0.
- R2: Each sample is sent as an I word (`port_iq`=0, `port_gain`=0) followed by a Q word (`port_iq`=1). In slave interleaved mode each of these words moves only in a cycle where `port_req` and `port_ack` are both high.
- R3: In paired mode (`cfg_parallel`=1), one accepted I word is followed in the very next cycle by its Q word, which moves without needing `port_ack`.
- R4: With `cfg_append_gain`=1, a third word carrying the gain value follows the Q word, with `port_gain`=1 and `port_iq`=0. In slave mode it needs its own acknowledge in both formats. With `cfg_append_gain`=0, `port_gain` never goes high.
- R5: `port_chan` carries the binary index (0 to 5) of the channel that owns the word. It stays constant for all words of one sample, and `port_iq` and `port_gain` are never high together.
- R6: In slave mode, while `port_req` is high and the word is not accepted, `port_data`, `port_chan`, `port_iq` and `port_gain` hold their values and `port_req` stays high.
- R7: In master mode (`cfg_master`=1), `port_ack` has no effect. Words go out on consecutive cycles, with no gap between samples that are already waiting.
- R8: When several enabled channels have samples waiting, the lowest channel index is sent first.
- R9: A channel whose `cfg_chan_en` bit is 0 ignores `in_valid`. Its data never appears on the port and it never sets its overflow flag.
- R10: A sample that arrives while the same channel's slot still holds an unsent sample replaces that sample, so only the newer one is sent. It also sets `ovf_flag` for that channel. The flag stays set until reset.
- R11: A sample that arrives while the channel's previous sample is already on the bus does not change the words in flight and does not set the overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock shared by all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master (ack ignored), 0 = slave |
| cfg_parallel | input | 1 | 1 = paired I/Q format, 0 = interleaved |
| cfg_append_gain | input | 1 | 1 = append the gain word after Q |
| cfg_chan_en | input | 6 | Per-channel enable, bit c for channel c |
| in_valid | input | 6 | New-sample strobe, bit c for channel c |
| in_i | input | 96 | I samples, channel c at bits [16c+15:16c] |
| in_q | input | 96 | Q samples, same packing |
| in_gain | input | 96 | Gain words, same packing |
| port_ack | input | 1 | Acknowledge from the receiver (slave mode) |
| port_req | output | 1 | A word is presented on the bus |
| port_data | output | 16 | Output word |
| port_chan | output | 3 | Channel index of the current word |
| port_iq | output | 1 | High on the Q word |
| port_gain | output | 1 | High on the gain word |
| ovf_flag | output | 6 | Sticky per-channel overflow flags |

## Verification
The hardest case to reach is an overwrite in a channel's holding slot: a second sample has to arrive while an earlier one is still waiting in the slot, and that slot is emptied as soon as the transmitter is free. The bench holds acknowledge low so that one sample of channel 0 stays stuck on the bus. It then sends a second sample, which must land in the slot without raising a flag, and a third, which must overwrite the second. Only after that does it grant the bus, and it checks that the first and third samples come out and the second is gone. Paired-mode gain appending is reached in a similar way: a single acknowledge pulse lets the I/Q pair through, and the bench then confirms that the gain word is still waiting for its own grant.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic [1:0] {
    PH_I = 2'd0,
    PH_Q = 2'd1,
    PH_G = 2'd2
  } phase_e;
endpackage

// File: rtl/sop_slot.sv
// One-sample holding slot for a single channel, with sticky overflow.
module sop_slot #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_i,
  input  logic [DW-1:0] in_q,
  input  logic [DW-1:0] in_g,
  input  logic          take,
  output logic          pend,
  output logic          ovf,
  output logic [DW-1:0] out_i,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] out_g
);
  logic accept;
  logic pend_n, ovf_n;

  always_comb begin
    accept = en & in_valid;
    pend_n = accept | (pend & ~take);
    ovf_n  = ovf | (accept & pend & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      pend <= pend_n;
      ovf  <= ovf_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_i <= '0;
      out_q <= '0;
      out_g <= '0;
    end else if (accept) begin
      out_i <= in_i;
      out_q <= in_q;
      out_g <= in_g;
    end
  end
endmodule

// File: rtl/sop_pick.sv
// Fixed-priority selector: lowest set index wins.
module sop_pick #(
  parameter int N   = 6,
  parameter int IW  = 3
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |req;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = i[IW-1:0];
    end
  end
endmodule

// File: rtl/sop_tx.sv
// Word sequencer: shadows one sample and steps through I, Q, gain.
module sop_tx
  import sop_pkg::*;
#(
  parameter int DW  = 16,
  parameter int CHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_master,
  input  logic           cfg_parallel,
  input  logic           cfg_append_gain,
  input  logic           port_ack,
  input  logic           cand_found,
  input  logic [CHW-1:0] cand_idx,
  input  logic [DW-1:0]  cand_i,
  input  logic [DW-1:0]  cand_q,
  input  logic [DW-1:0]  cand_g,
  output logic           load,
  output logic           port_req,
  output logic [DW-1:0]  port_data,
  output logic [CHW-1:0] port_chan,
  output logic           port_iq,
  output logic           port_gain
);
  logic           busy, busy_n;
  phase_e         phase, phase_n;
  logic [CHW-1:0] sh_ch, sh_ch_n;
  logic [DW-1:0]  sh_i, sh_q, sh_g;
  logic [DW-1:0]  sh_i_n, sh_q_n, sh_g_n;
  logic           fire, last;

  always_comb begin
    fire = busy & (cfg_master | port_ack | (cfg_parallel & (phase == PH_Q)));
    last = (phase == PH_G) | ((phase == PH_Q) & ~cfg_append_gain);
    load = cand_found & (~busy | (fire & last));

    busy_n  = busy;
    phase_n = phase;
    sh_ch_n = sh_ch;
    sh_i_n  = sh_i;
    sh_q_n  = sh_q;
    sh_g_n  = sh_g;
    if (load) begin
      busy_n  = 1'b1;
      phase_n = PH_I;
      sh_ch_n = cand_idx;
      sh_i_n  = cand_i;
      sh_q_n  = cand_q;
      sh_g_n  = cand_g;
    end else if (fire) begin
      if (last) busy_n = 1'b0;
      else      phase_n = (phase == PH_I) ? PH_Q : PH_G;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= PH_I;
      sh_ch <= '0;
      sh_i  <= '0;
      sh_q  <= '0;
      sh_g  <= '0;
    end else begin
      busy  <= busy_n;
      phase <= phase_n;
      sh_ch <= sh_ch_n;
      sh_i  <= sh_i_n;
      sh_q  <= sh_q_n;
      sh_g  <= sh_g_n;
    end
  end

  always_comb begin
    port_req  = busy;
    port_chan = sh_ch;
    port_iq   = busy & (phase == PH_Q);
    port_gain = busy & (phase == PH_G);
    case (phase)
      PH_Q:    port_data = sh_q;
      PH_G:    port_data = sh_g;
      default: port_data = sh_i;
    endcase
  end
endmodule

// File: rtl/sample_out_port.sv
module sample_out_port #(
  parameter int NCH = 6,
  parameter int DW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_master,
  input  logic            cfg_parallel,
  input  logic            cfg_append_gain,
  input  logic [NCH-1:0]  cfg_chan_en,
  input  logic [NCH-1:0]  in_valid,
  input  logic [NCH*DW-1:0] in_i,
  input  logic [NCH*DW-1:0] in_q,
  input  logic [NCH*DW-1:0] in_gain,
  input  logic            port_ack,
  output logic            port_req,
  output logic [DW-1:0]   port_data,
  output logic [CHW-1:0]  port_chan,
  output logic            port_iq,
  output logic            port_gain,
  output logic [NCH-1:0]  ovf_flag
);
  logic [NCH-1:0] pend, take;
  logic [DW-1:0]  s_i [NCH];
  logic [DW-1:0]  s_q [NCH];
  logic [DW-1:0]  s_g [NCH];
  logic           cand_found, load;
  logic [CHW-1:0] cand_idx;

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    assign take[c] = load & (cand_idx == CHW'(c));
    sop_slot #(.DW(DW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (cfg_chan_en[c]),
      .in_valid (in_valid[c]),
      .in_i     (in_i[c*DW +: DW]),
      .in_q     (in_q[c*DW +: DW]),
      .in_g     (in_gain[c*DW +: DW]),
      .take     (take[c]),
      .pend     (pend[c]),
      .ovf      (ovf_flag[c]),
      .out_i    (s_i[c]),
      .out_q    (s_q[c]),
      .out_g    (s_g[c])
    );
  end

  sop_pick #(.N(NCH), .IW(CHW)) u_pick (
    .req   (pend & cfg_chan_en),
    .found (cand_found),
    .idx   (cand_idx)
  );

  sop_tx #(.DW(DW), .CHW(CHW)) u_tx (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_master      (cfg_master),
    .cfg_parallel    (cfg_parallel),
    .cfg_append_gain (cfg_append_gain),
    .port_ack        (port_ack),
    .cand_found      (cand_found),
    .cand_idx        (cand_idx),
    .cand_i          (s_i[cand_idx]),
    .cand_q          (s_q[cand_idx]),
    .cand_g          (s_g[cand_idx]),
    .load            (load),
    .port_req        (port_req),
    .port_data       (port_data),
    .port_chan       (port_chan),
    .port_iq         (port_iq),
    .port_gain       (port_gain)
  );
endmodule

// File: rtl/sop_checker.sv
module sop_checker #(
  parameter int NCH = 6,
  parameter int DW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_master,
  input logic           cfg_parallel,
  input logic           cfg_append_gain,
  input logic [NCH-1:0] cfg_chan_en,
  input logic           port_ack,
  input logic           port_req,
  input logic [DW-1:0]  port_data,
  input logic [CHW-1:0] port_chan,
  input logic           port_iq,
  input logic           port_gain,
  input logic [NCH-1:0] ovf_flag
);
  logic xfer;
  assign xfer = port_req & (cfg_master | port_ack | (cfg_parallel & port_iq));

  // R6: an unaccepted word is held unchanged
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_req && !xfer) |=> (port_req && $stable(port_data) && $stable(port_chan)
                             && $stable(port_iq) && $stable(port_gain)));

  // R2: accepted I word is followed by Q of the same channel
  assert_q_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !port_iq && !port_gain) |=> (port_req && port_iq && $stable(port_chan)));

  // R3: in paired mode the Q word moves in the cycle after I
  assert_pair_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_parallel && xfer && !port_iq && !port_gain) |=> xfer);

  // R4: gain word follows Q when appending is on
  assert_gain_after_q_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && port_iq && cfg_append_gain) |=> (port_req && port_gain && $stable(port_chan)));

  // R4: no gain word without appending
  assert_no_gain_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_append_gain |-> !port_gain);

  // R5: flags exclusive, channel index in range
  assert_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_iq && port_gain));
  assert_chan_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    port_req |-> (int'(port_chan) < NCH));

  // R9: only enabled channels appear on the port
  assert_enabled_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
    port_req |-> ((cfg_chan_en >> port_chan) & NCH'(1)) != '0);

  // R10: overflow flags never clear
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag)));
endmodule

bind sample_out_port sop_checker #(.NCH(NCH), .DW(DW)) u_chk (.*);

// File: tb/tb_sample_out_port.sv
module tb_sample_out_port;
  localparam int NCH = 6;
  localparam int DW  = 16;

  logic            clk;
  logic            rst_n;
  logic            cfg_master, cfg_parallel, cfg_append_gain;
  logic [NCH-1:0]  cfg_chan_en, in_valid;
  logic [NCH*DW-1:0] in_i, in_q, in_gain;
  logic            port_ack;
  logic            port_req;
  logic [DW-1:0]   port_data;
  logic [2:0]      port_chan;
  logic            port_iq, port_gain;
  logic [NCH-1:0]  ovf_flag;

  sample_out_port #(.NCH(NCH), .DW(DW)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nw = 0;
  logic [DW-1:0] w_data [64];
  logic [2:0]    w_chan [64];
  logic          w_iq   [64];
  logic          w_gain [64];
  int            w_cyc  [64];

  always @(posedge clk) cyc <= cyc + 1;

  // Word monitor, sampling between the drive edge and the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && port_req && (cfg_master || port_ack || (cfg_parallel && port_iq))) begin
      if (nw < 64) begin
        w_data[nw] = port_data;
        w_chan[nw] = port_chan;
        w_iq[nw]   = port_iq;
        w_gain[nw] = port_gain;
        w_cyc[nw]  = cyc;
      end
      nw++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] vi(input int ch, input int n);
    return DW'(16'h1000 + ch * 16 + n);
  endfunction
  function automatic logic [DW-1:0] vq(input int ch, input int n);
    return DW'(16'h2000 + ch * 16 + n);
  endfunction
  function automatic logic [DW-1:0] vg(input int ch, input int n);
    return DW'(16'h3000 + ch * 16 + n);
  endfunction

  task automatic put(input int ch, input int n);
    in_i[ch*DW +: DW]    = vi(ch, n);
    in_q[ch*DW +: DW]    = vq(ch, n);
    in_gain[ch*DW +: DW] = vg(ch, n);
    in_valid[ch]         = 1'b1;
  endtask

  task automatic strobe();
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic drain();
    repeat (14) @(negedge clk);
  endtask

  task automatic wait_req();
    while (!port_req) @(negedge clk);
    #2;
  endtask

  task automatic setup(input bit m, input bit p, input bit a, input bit ack);
    @(negedge clk);
    cfg_master = m; cfg_parallel = p; cfg_append_gain = a; port_ack = ack;
    cfg_chan_en = '1;
    @(negedge clk);
    nw = 0;
  endtask

  task automatic t_reset();
    chk(port_req == 1'b0, "R1 req", int'(port_req), 0);
    chk(port_iq == 1'b0 && port_gain == 1'b0, "R1 flags", int'({port_iq, port_gain}), 0);
    chk(ovf_flag == '0, "R1 ovf", int'(ovf_flag), 0);
  endtask

  task automatic t_interleaved();
    setup(1'b0, 1'b0, 1'b0, 1'b1);
    put(2, 1); strobe(); drain();
    chk(nw == 2, "R2 word count", nw, 2);
    chk(w_data[0] == vi(2, 1) && !w_iq[0] && !w_gain[0], "R2 I word", int'(w_data[0]), int'(vi(2, 1)));
    chk(w_data[1] == vq(2, 1) && w_iq[1], "R2 Q word", int'(w_data[1]), int'(vq(2, 1)));
    chk(w_chan[0] == 3'd2 && w_chan[1] == 3'd2, "R5 channel index", int'(w_chan[1]), 2);
  endtask

  task automatic t_hold();
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    put(1, 2); strobe(); wait_req();
    repeat (4) @(negedge clk);
    #2;
    chk(nw == 0 && port_req && port_data == vi(1, 2), "R6 held I", int'(port_data), int'(vi(1, 2)));
    @(negedge clk); port_ack = 1'b1;
    @(negedge clk); port_ack = 1'b0;
    repeat (4) @(negedge clk);
    #2;
    chk(nw == 1, "R2 one word per ack", nw, 1);
    chk(port_req && port_iq && port_data == vq(1, 2), "R6 held Q", int'(port_data), int'(vq(1, 2)));
    port_ack = 1'b1;
    drain();
    chk(nw == 2 && w_data[1] == vq(1, 2), "R2 Q after ack", nw, 2);
  endtask

  task automatic t_parallel();
    setup(1'b0, 1'b1, 1'b0, 1'b0);
    put(3, 3); strobe(); wait_req();
    @(negedge clk); port_ack = 1'b1;
    @(negedge clk); port_ack = 1'b0;
    drain();
    chk(nw == 2, "R3 pair on one ack", nw, 2);
    chk(w_iq[1] && w_data[1] == vq(3, 3), "R3 Q data", int'(w_data[1]), int'(vq(3, 3)));
    chk(w_cyc[1] == w_cyc[0] + 1, "R3 Q next cycle", w_cyc[1] - w_cyc[0], 1);
    chk(!port_req, "R3 port idle", int'(port_req), 0);
  endtask

  task automatic t_gain();
    setup(1'b0, 1'b0, 1'b1, 1'b1);
    put(4, 4); strobe(); drain();
    chk(nw == 3, "R4 three words", nw, 3);
    chk(w_gain[2] && !w_iq[2] && w_data[2] == vg(4, 4), "R4 gain word", int'(w_data[2]), int'(vg(4, 4)));
    chk(w_chan[2] == 3'd4, "R5 chan on gain", int'(w_chan[2]), 4);
    setup(1'b0, 1'b1, 1'b1, 1'b0);
    put(0, 5); strobe(); wait_req();
    @(negedge clk); port_ack = 1'b1;
    @(negedge clk); port_ack = 1'b0;
    repeat (5) @(negedge clk);
    #2;
    chk(nw == 2 && port_req && port_gain, "R4 gain waits for ack", nw, 2);
    port_ack = 1'b1;
    drain();
    chk(nw == 3 && w_data[2] == vg(0, 5), "R4 gain after ack", int'(w_data[2]), int'(vg(0, 5)));
  endtask

  task automatic t_master();
    setup(1'b1, 1'b0, 1'b0, 1'b0);
    put(5, 6); put(0, 6); put(4, 6); strobe(); drain();
    chk(nw == 6, "R7 master words with ack low", nw, 6);
    for (int k = 0; k < 6; k++)
      chk(w_cyc[k] == w_cyc[0] + k, "R7 consecutive cycles", w_cyc[k] - w_cyc[0], k);
    chk(w_chan[0] == 3'd0 && w_chan[2] == 3'd4 && w_chan[4] == 3'd5, "R8 ascending order",
        int'({w_chan[0], w_chan[2], w_chan[4]}), 'o045);
  endtask

  task automatic t_order();
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    put(5, 7); put(1, 7); strobe();
    @(negedge clk); port_ack = 1'b1;
    drain();
    chk(nw == 4 && w_chan[0] == 3'd1 && w_chan[2] == 3'd5, "R8 slave order", int'(w_chan[0]), 1);
  endtask

  task automatic t_disable();
    setup(1'b0, 1'b0, 1'b0, 1'b1);
    cfg_chan_en = 6'b111011;
    put(2, 8); strobe();
    put(2, 9); strobe(); drain();
    chk(nw == 0, "R9 disabled not sent", nw, 0);
    chk(ovf_flag[2] == 1'b0, "R9 no overflow", int'(ovf_flag), 0);
    cfg_chan_en = '1;
  endtask

  task automatic t_overflow();
    setup(1'b0, 1'b0, 1'b0, 1'b0);
    put(0, 10); strobe();
    repeat (3) @(negedge clk);
    put(0, 11); strobe();
    repeat (2) @(negedge clk);
    chk(ovf_flag == '0, "R11 in-flight no flag", int'(ovf_flag), 0);
    chk(port_data == vi(0, 10), "R11 words in flight kept", int'(port_data), int'(vi(0, 10)));
    put(0, 12); strobe();
    chk(ovf_flag == 6'b000001, "R10 overflow set", int'(ovf_flag), 1);
    port_ack = 1'b1;
    drain();
    chk(nw == 4, "R10 two samples sent", nw, 4);
    chk(w_data[0] == vi(0, 10) && w_data[2] == vi(0, 12), "R10 newest kept",
        int'(w_data[2]), int'(vi(0, 12)));
    put(0, 13); strobe(); drain();
    chk(ovf_flag == 6'b000001, "R10 sticky", int'(ovf_flag), 1);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_master = 1'b0; cfg_parallel = 1'b0; cfg_append_gain = 1'b0;
    cfg_chan_en = '1; in_valid = '0; in_i = '0; in_q = '0; in_gain = '0;
    port_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_interleaved();
    t_hold();
    t_parallel();
    t_gain();
    t_master();
    t_order();
    t_disable();
    t_overflow();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule